// File: doc/BRIEF.md
# Character Display Host Bus Interface

This block sits between a microcontroller-style parallel bus and the core of a character display controller. The host drives a register select line, a read/write line, an enable strobe and an 8-line data bus. Inside the chip the data bus appears as three separate signals: one for input, one for output and one for output enable. The block decodes each host access and sends it to the right place. With register select low, a write goes to the instruction register and a read returns a status byte. With register select high, both reads and writes go to the data register. The status byte carries the core's busy flag on bit 7 and the address counter on bits 6 to 0.

The bus runs either 8 bits wide or in nibble mode. In nibble mode each byte crosses the upper four data lines in two enable pulses, high nibble first, and the lower four lines are ignored. A configuration load pulse sets the width and clears the nibble toggle, so the next nibble is taken as a high nibble.

The enable strobe is asynchronous to the block clock. It passes through a two-stage synchroniser with edge detection. When an access completes, the block sends the core a one-cycle write strobe (`wr_valid_o`) carrying the register selected and the full byte. A completed data register read gives a one-cycle `rd_valid_o` pulse instead. The core takes these strobes with no ready signal and applies no back-pressure. The host paces itself by polling the busy flag, because a parallel host bus cannot be stalled.

Top module: `lcd_host_if`

## Requirements
- R1: After reset `wr_valid_o`, `rd_valid_o` and `bus_d_oe_o` are 0, and the nibble toggle expects a high nibble.
- R2: In 8-bit mode, a write with `bus_rs_i`=0 pulses `wr_valid_o` for exactly one cycle, with `wr_sel_o`=0 and `wr_byte_o` equal to the bus byte. The pulse is seen in the third clock cycle after enable falls.
- R3: In 8-bit mode, a write with `bus_rs_i`=1 gives the same pulse with `wr_sel_o`=1 (data register).
- R4: A read with `bus_rs_i`=0 drives the status byte. Bit 7 is `core_busy_i` and bits 6..0 are `core_addr_i`.
- R5: A read with `bus_rs_i`=1 drives `core_rd_byte_i`. When the read completes, `rd_valid_o` pulses for one cycle, three cycles after enable falls.
- R6: `bus_d_oe_o` is 1 only while the synchronised enable is high during a read (`bus_rw_i`=1). It rises three cycles after enable rises, and it never rises during a write.
- R7: In nibble mode (`cfg_nibble_i`=1), a write takes the high nibble from lines 7..4 on the first pulse and the low nibble from lines 7..4 on the second pulse. Lines 3..0 are ignored. A single write strobe follows only the second pulse.
- R8: In nibble mode, a read drives the high nibble on lines 7..4 first and the low nibble second. Lines 3..0 are driven 0.
- R9: A `cfg_load_i` pulse clears the nibble toggle, so a half-finished byte is discarded.
- R10: A status read gives no `rd_valid_o` pulse, and neither does the first nibble of a nibble-mode access.
- R11: Read data is captured when enable rises. Changes to `core_rd_byte_i` while enable stays high do not alter the driven byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rs_i | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_rw_i | input | 1 | 1 read, 0 write |
| bus_en_i | input | 1 | Asynchronous access strobe |
| bus_d_i | input | DATA_W | Data bus input |
| bus_d_o | output | DATA_W | Data bus output value |
| bus_d_oe_o | output | 1 | Data bus output enable |
| cfg_nibble_i | input | 1 | 1 selects nibble mode |
| cfg_load_i | input | 1 | Pulse: bus width set, clears nibble toggle |
| core_busy_i | input | 1 | Core busy flag |
| core_addr_i | input | DATA_W-1 | Core address counter |
| core_rd_byte_i | input | DATA_W | Data register read value |
| wr_valid_o | output | 1 | One-cycle write strobe to core |
| wr_sel_o | output | 1 | Target of the write: 0 instruction, 1 data |
| wr_byte_o | output | DATA_W | Assembled write byte |
| rd_valid_o | output | 1 | One-cycle completed data-read strobe |

## Verification
Each result lands at a fixed cycle. Output enable and read data become valid in the third cycle after enable rises. The write and read strobes appear in the third cycle after enable falls: two synchroniser stages, then one output register. The bench changes inputs on falling clock edges and counts falling edges from each enable transition. It checks that output enable is still low at the second edge and high at the third. For the strobes it records the exact edge on which each appears and compares that with 3, or with "never" where no strobe may occur.

// File: rtl/lcd_host_pkg.sv
package lcd_host_pkg;
  // Nibble position of the next transfer in nibble mode
  typedef enum logic {
    NIB_HI = 1'b0,
    NIB_LO = 1'b1
  } nib_pos_e;
endpackage

// File: rtl/lcd_en_sync.sv
module lcd_en_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  // STAGES synchroniser flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], en_i};
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o  = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/lcd_wr_assembler.sv
module lcd_wr_assembler
  import lcd_host_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  input  logic              rs_i,
  input  logic              rw_i,
  input  logic [DATA_W-1:0] d_i,
  input  logic              nibble_i,
  input  logic              load_i,
  output nib_pos_e          pos_o,
  output logic              wr_valid_o,
  output logic              wr_sel_o,
  output logic [DATA_W-1:0] wr_byte_o,
  output logic              rd_valid_o
);
  localparam int NIB_W = DATA_W / 2;

  nib_pos_e           pos_q;
  logic [NIB_W-1:0]   hi_q;
  logic               done;

  // An access finishes on every fall in 8-bit mode, on the second fall in nibble mode
  assign done = fall_i & (~nibble_i | (pos_q == NIB_LO));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q      <= NIB_HI;
      hi_q       <= '0;
      wr_valid_o <= 1'b0;
      wr_sel_o   <= 1'b0;
      wr_byte_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      wr_valid_o <= 1'b0;
      rd_valid_o <= 1'b0;
      if (load_i) begin
        pos_q <= NIB_HI;
      end else if (fall_i) begin
        if (nibble_i) begin
          pos_q <= (pos_q == NIB_HI) ? NIB_LO : NIB_HI;
          if (pos_q == NIB_HI && !rw_i) hi_q <= d_i[DATA_W-1:NIB_W];
        end
        if (done) begin
          if (!rw_i) begin
            wr_valid_o <= 1'b1;
            wr_sel_o   <= rs_i;
            wr_byte_o  <= nibble_i ? {hi_q, d_i[DATA_W-1:NIB_W]} : d_i;
          end else if (rs_i) begin
            rd_valid_o <= 1'b1;
          end
        end
      end
    end
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/lcd_rd_mux.sv
module lcd_rd_mux
  import lcd_host_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              level_i,
  input  logic              rs_i,
  input  logic              rw_i,
  input  logic              nibble_i,
  input  nib_pos_e          pos_i,
  input  logic              busy_i,
  input  logic [DATA_W-2:0] addr_i,
  input  logic [DATA_W-1:0] rd_byte_i,
  output logic [DATA_W-1:0] d_o,
  output logic              oe_o
);
  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W-1:0] snap_q;
  logic              oe_q;
  logic              take;

  // Capture a fresh byte at the first enable rise of each access
  assign take = rise_i & (~nibble_i | (pos_i == NIB_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= level_i & rw_i;
      if (take) snap_q <= rs_i ? rd_byte_i : {busy_i, addr_i};
    end
  end

  always_comb begin
    if (nibble_i)
      d_o = {(pos_i == NIB_LO) ? snap_q[NIB_W-1:0] : snap_q[DATA_W-1:NIB_W], {NIB_W{1'b0}}};
    else
      d_o = snap_q;
  end

  assign oe_o = oe_q;
endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if
  import lcd_host_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rs_i,
  input  logic              bus_rw_i,
  input  logic              bus_en_i,
  input  logic [DATA_W-1:0] bus_d_i,
  output logic [DATA_W-1:0] bus_d_o,
  output logic              bus_d_oe_o,
  input  logic              cfg_nibble_i,
  input  logic              cfg_load_i,
  input  logic              core_busy_i,
  input  logic [DATA_W-2:0] core_addr_i,
  input  logic [DATA_W-1:0] core_rd_byte_i,
  output logic              wr_valid_o,
  output logic              wr_sel_o,
  output logic [DATA_W-1:0] wr_byte_o,
  output logic              rd_valid_o
);
  logic     en_lvl, en_rise, en_fall;
  nib_pos_e pos;

  lcd_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (bus_en_i),
    .level_o (en_lvl),
    .rise_o  (en_rise),
    .fall_o  (en_fall)
  );

  lcd_wr_assembler #(.DATA_W(DATA_W)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .fall_i     (en_fall),
    .rs_i       (bus_rs_i),
    .rw_i       (bus_rw_i),
    .d_i        (bus_d_i),
    .nibble_i   (cfg_nibble_i),
    .load_i     (cfg_load_i),
    .pos_o      (pos),
    .wr_valid_o (wr_valid_o),
    .wr_sel_o   (wr_sel_o),
    .wr_byte_o  (wr_byte_o),
    .rd_valid_o (rd_valid_o)
  );

  lcd_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_i    (en_rise),
    .level_i   (en_lvl),
    .rs_i      (bus_rs_i),
    .rw_i      (bus_rw_i),
    .nibble_i  (cfg_nibble_i),
    .pos_i     (pos),
    .busy_i    (core_busy_i),
    .addr_i    (core_addr_i),
    .rd_byte_i (core_rd_byte_i),
    .d_o       (bus_d_o),
    .oe_o      (bus_d_oe_o)
  );
endmodule

// File: rtl/lcd_host_if_chk.sv
module lcd_host_if_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rw_i,
  input logic [DATA_W-1:0] bus_d_o,
  input logic              bus_d_oe_o,
  input logic              cfg_nibble_i,
  input logic              wr_valid_o,
  input logic              rd_valid_o
);
  localparam int NIB_W = DATA_W / 2;

  // R2
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);

  // R5
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |=> !rd_valid_o);

  // R6
  oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_d_oe_o) |-> $past(bus_rw_i));

  // R6
  oe_not_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> !bus_d_oe_o);

  // R8
  low_lines_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_nibble_i && bus_d_oe_o) |-> (bus_d_o[NIB_W-1:0] == '0));

  // R10
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid_o && rd_valid_o));
endmodule

bind lcd_host_if lcd_host_if_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/lcd_host_if_test.sv
module lcd_host_if_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rs_i = 1'b1, bus_rw_i = 1'b1, bus_en_i = 1'b0;
  logic [7:0] bus_d_i = 8'hFF;
  logic [7:0] bus_d_o;
  logic       bus_d_oe_o;
  logic       cfg_nibble_i = 1'b0, cfg_load_i = 1'b0;
  logic       core_busy_i = 1'b0;
  logic [6:0] core_addr_i = '0;
  logic [7:0] core_rd_byte_i = '0;
  logic       wr_valid_o, wr_sel_o, rd_valid_o;
  logic [7:0] wr_byte_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lcd_host_if uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Results of the last access
  logic [7:0] r_byte, w_byte;
  logic       w_sel, oe2, oe3, oe_any;
  int         wr_at, rd_at;

  task automatic access(input logic rs, input logic rw, input logic [7:0] d);
    wr_at = 0; rd_at = 0; oe_any = 1'b0;
    @(negedge clk); bus_rs_i = rs; bus_rw_i = rw; bus_d_i = d;
    @(negedge clk); bus_en_i = 1'b1;
    @(negedge clk);
    @(negedge clk); oe2 = bus_d_oe_o;
    @(negedge clk); oe3 = bus_d_oe_o;
    @(negedge clk); oe_any = oe_any | bus_d_oe_o;
    if (rs && rw) core_rd_byte_i = ~core_rd_byte_i;   // perturb after capture
    @(negedge clk); r_byte = bus_d_o; oe_any = oe_any | bus_d_oe_o;
    if (rs && rw) core_rd_byte_i = ~core_rd_byte_i;
    bus_en_i = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (wr_valid_o && wr_at == 0) begin wr_at = k; w_byte = wr_byte_o; w_sel = wr_sel_o; end
      if (rd_valid_o && rd_at == 0) rd_at = k;
    end
  endtask

  task automatic t_reset;
    check("R1 wr_valid", wr_valid_o, 0);
    check("R1 rd_valid", rd_valid_o, 0);
    check("R1 oe", bus_d_oe_o, 0);
  endtask

  task automatic t_write8;
    access(1'b0, 1'b0, 8'h38);
    check("R2 strobe cycle", wr_at, 3);
    check("R2 byte", w_byte, 8'h38);
    check("R2 sel", w_sel, 0);
    check("R6 no oe on write", oe3 | oe_any, 0);
    access(1'b1, 1'b0, 8'hA5);
    check("R3 strobe cycle", wr_at, 3);
    check("R3 byte", w_byte, 8'hA5);
    check("R3 sel", w_sel, 1);
  endtask

  task automatic t_status;
    core_busy_i = 1'b1; core_addr_i = 7'h2B;
    access(1'b0, 1'b1, 8'hFF);
    check("R4 busy status byte", r_byte, 8'hAB);
    check("R10 no rd strobe on status", rd_at, 0);
    check("R6 oe not yet at cycle 2", oe2, 0);
    check("R6 oe at cycle 3", oe3, 1);
    core_busy_i = 1'b0; core_addr_i = 7'h7F;
    access(1'b0, 1'b1, 8'hFF);
    check("R4 idle status byte", r_byte, 8'h7F);
    check("R2 no write strobe on read", wr_at, 0);
  endtask

  task automatic t_read8;
    core_rd_byte_i = 8'h5C;
    access(1'b1, 1'b1, 8'hFF);
    check("R5 data byte", r_byte, 8'h5C);
    check("R11 held snapshot", r_byte, 8'h5C);
    check("R5 rd strobe cycle", rd_at, 3);
    check("R6 oe dropped after fall", bus_d_oe_o, 0);
  endtask

  task automatic t_write4;
    @(negedge clk); cfg_nibble_i = 1'b1; cfg_load_i = 1'b1;
    @(negedge clk); cfg_load_i = 1'b0;
    access(1'b1, 1'b0, 8'h35);
    check("R10 R7 no strobe after first nibble", wr_at, 0);
    access(1'b1, 1'b0, 8'hCA);
    check("R7 strobe after second nibble", wr_at, 3);
    check("R7 assembled byte", w_byte, 8'h3C);
    check("R7 sel", w_sel, 1);
  endtask

  task automatic t_read4;
    core_rd_byte_i = 8'h96;
    access(1'b1, 1'b1, 8'hFF);
    check("R8 high nibble first", r_byte, 8'h90);
    check("R10 no rd strobe mid-byte", rd_at, 0);
    access(1'b1, 1'b1, 8'hFF);
    check("R8 low nibble second", r_byte, 8'h60);
    check("R5 rd strobe after second nibble", rd_at, 3);
  endtask

  task automatic t_mode_reset;
    access(1'b0, 1'b0, 8'hE0);
    @(negedge clk); cfg_load_i = 1'b1;
    @(negedge clk); cfg_load_i = 1'b0;
    access(1'b0, 1'b0, 8'h4F);
    check("R9 first nibble after load", wr_at, 0);
    access(1'b0, 1'b0, 8'h20);
    check("R9 strobe cycle", wr_at, 3);
    check("R9 byte after toggle cleared", w_byte, 8'h42);
    check("R9 sel", w_sel, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write8();
    t_status();
    t_read8();
    t_write4();
    t_read4();
    t_mode_reset();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule